// File: doc/BRIEF.md
# Change-Triggered Programmable Delay Timer

This block produces a delay of a programmable number of clock periods. The delay length comes in on a multi-bit value input, and there is no separate start command. On every clock edge the block compares the input with the value it registered on the previous edge. When the two differ, an internal down-counter is loaded with the new input. The counter then drops by one on each following clock until it reaches zero, and it stays at zero.

The single status output, ready, is high exactly when the counter is zero. Ready low therefore means a delay is still running. If the input changes again during a countdown, the counter is reloaded with the newest value and the countdown starts over. Changing the input to zero ends any running delay at the next edge.

The delay is always a whole number of clock periods. The input is expected to be synchronous to the clock.

Top module: `chg_delay_timer`

## Requirements
- R1: While rst_ni is low, ready_o is 1. Reset clears both the counter and the stored previous value to zero, so an input held at 0 after reset starts no delay and ready_o stays 1.
- R2: On the clock edge at which value_i differs from the value stored on the previous edge and is non-zero, ready_o goes to 0.
- R3: After a change to a non-zero value V, ready_o stays 0 for exactly V clock edges, counting the loading edge, and is 1 after the following edge.
- R4: While value_i is held constant after a countdown completes, no reload happens and ready_o stays 1.
- R5: A change of value_i during a countdown reloads the counter with the newest value, and the full new delay is measured from that edge.
- R6: A change of value_i to 0 makes ready_o 1 at that edge, including when a countdown was running.
- R7: Once the counter is at zero it holds there and does not wrap, so ready_o stays 1 until the next change.
- R8: Every change counts, including a return to an earlier value (A, B, A) and the largest value 2^WIDTH-1, which gives 2^WIDTH-1 low cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| value_i | input | WIDTH | Delay length in clock periods; a change starts a new countdown |
| ready_o | output | 1 | 1 when no delay is running (counter at zero) |

## Verification
The assertions assume that value_i is synchronous to clk_i and settles before each rising edge. They treat any difference from the registered copy as a real change, because the block has no filtering for glitches. The bench meets this by changing value_i only on falling edges. It compares against a cycle model that is advanced once per rising edge. It covers holding the input, changing it mid-countdown, changing it to zero and returning to an earlier value.

// File: rtl/chg_delay_pkg.sv
package chg_delay_pkg;
  parameter int unsigned DFLT_WIDTH = 8;
endpackage

// File: rtl/chg_delay_detect.sv
module chg_delay_detect #(
  parameter int unsigned WIDTH = chg_delay_pkg::DFLT_WIDTH
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] value_i,
  output logic             chg_o
);
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= value_i;
  end

  assign chg_o = (value_i != prev_q);

  // R4: after a change is taken, only a further input change flags again
  a_r4_no_spurious_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_o |=> (chg_o == (value_i != $past(value_i))));
endmodule

// File: rtl/chg_delay_count.sv
module chg_delay_count #(
  parameter int unsigned WIDTH = chg_delay_pkg::DFLT_WIDTH
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [WIDTH-1:0] load_val_i,
  output logic             zero_o
);
  logic [WIDTH-1:0] cnt_q;
  logic [WIDTH-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)           cnt_d = load_val_i;
    else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);

  a_r5_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == $past(load_val_i)));

  a_r3_decrement: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

  a_r7_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && zero_o) |=> zero_o);
endmodule

// File: rtl/chg_delay_timer.sv
module chg_delay_timer #(
  parameter int unsigned WIDTH = chg_delay_pkg::DFLT_WIDTH
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] value_i,
  output logic             ready_o
);
  logic chg;

  chg_delay_detect #(.WIDTH(WIDTH)) u_detect (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .value_i (value_i),
    .chg_o   (chg)
  );

  chg_delay_count #(.WIDTH(WIDTH)) u_count (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (chg),
    .load_val_i (value_i),
    .zero_o     (ready_o)
  );

  a_r6_zero_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chg && value_i == '0) |=> ready_o);

  a_r2_busy_on_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chg && value_i != '0) |=> !ready_o);

  always_comb begin
    if (!rst_ni) a_r1_reset_ready: assert (ready_o);
  end
endmodule

// File: tb/chg_delay_timer_tb_top.sv
module chg_delay_timer_tb_top;
  localparam int unsigned WIDTH = 8;
  localparam time CLK_PERIOD = 10ns;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic [WIDTH-1:0] value_i = '0;
  logic             ready_o;

  int checks = 0;
  int fails = 0;

  typedef struct {
    logic  rdy;
    string req;
  } exp_t;
  exp_t exp_q[$];

  int unsigned m_prev = 0;
  int unsigned m_cnt = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  chg_delay_timer #(.WIDTH(WIDTH)) dut_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .value_i (value_i),
    .ready_o (ready_o)
  );

  // driver: one input per cycle, expected ready after the next rising edge
  task automatic drive(input int unsigned v, input string req);
    exp_t e;
    @(negedge clk_i);
    value_i = v[WIDTH-1:0];
    if (v != m_prev) begin
      m_cnt  = v;
      m_prev = v;
    end else if (m_cnt != 0) begin
      m_cnt = m_cnt - 1;
    end
    e.rdy = (m_cnt == 0);
    e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic hold(input int unsigned v, input int n, input string req);
    for (int i = 0; i < n; i++) drive(v, req);
  endtask

  // monitor
  always @(posedge clk_i) begin
    exp_t e;
    #(CLK_PERIOD/4);
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      checks++;
      if (ready_o !== e.rdy) begin
        fails++;
        $display("FAIL %s ready_o actual=%b expected=%b", e.req, ready_o, e.rdy);
      end
    end
  end

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    value_i = 8'd37;
    repeat (3) @(negedge clk_i);
    checks++;
    if (ready_o !== 1'b1) begin
      fails++;
      $display("FAIL R1 reset ready_o actual=%b expected=1", ready_o);
    end
    value_i = '0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    hold(0, 3, "R1");
    drive(5, "R2");
    hold(5, 5, "R3");
    hold(5, 4, "R4");
    drive(9, "R2");
    hold(9, 2, "R5");
    drive(4, "R5");
    hold(4, 5, "R5");
    drive(7, "R2");
    hold(7, 2, "R6");
    drive(0, "R6");
    hold(0, 4, "R7");
    drive(3, "R8");
    drive(1, "R8");
    drive(3, "R8");
    hold(3, 4, "R8");
    drive(1, "R3");
    hold(1, 2, "R3");
    drive(255, "R8");
    hold(255, 258, "R8");
    drive(2, "R5");
    hold(2, 3, "R7");
    @(negedge clk_i);
    @(negedge clk_i);
    finish_run();
  end
endmodule